// File: doc/BRIEF.md
# PS/2 Cursor-Key State Tracker

This block listens to the clock and data lines of a PS/2 keyboard and keeps a live record of which of the four cursor keys are held down. It resynchronises both lines into the system clock domain and samples data on each falling keyboard clock. It assembles 11-bit frames and runs a small prefix parser over the accepted bytes. The parser recognises the extended press sequence (prefix byte 0xE0 then a key code) and the extended release sequence (0xE0, 0xF0, then a key code). A matching press sets one bit of a 4-bit held-key vector. A matching release clears that bit.

A processor reads the vector through an I/O read port. When the 4-bit port identifier equals 12, the port returns the held-key vector in the low nibble with zeros above it. Any other identifier reads as zero. Frames that fail their checks are dropped. A frame left unfinished by a silent keyboard is dropped by an idle-clock timeout, so the next complete frame is received cleanly.

Top module: `ps2_arrow_tracker`

## Requirements
- R1: After reset the held-key vector is 0 and the port reads 0 at every identifier.
- R2: A frame is a 0 start bit, eight data bits least significant first, an odd parity bit and a 1 stop bit. Each bit is taken on a falling edge of the keyboard clock after a two-stage synchroniser.
- R3: The press sequence 0xE0 followed by a cursor code sets that key's bit.
- R4: The release sequence 0xE0, 0xF0 followed by a cursor code clears that key's bit.
- R5: Bit 0 is up (0x72), bit 1 is down (0x75), bit 2 is left (0x6B) and bit 3 is right (0x74). Each bit changes independently of the others.
- R6: Cursor codes without the 0xE0 prefix, alone or after a bare 0xF0, leave the vector unchanged.
- R7: After 0xE0, any byte other than 0xF0 or a cursor code returns the parser to idle. A later cursor code with no fresh 0xE0 is then ignored.
- R8: A frame with wrong parity is discarded and returns the parser to idle without changing the vector.
- R9: A frame whose stop bit is 0 is discarded and returns the parser to idle without changing the vector.
- R10: If no falling keyboard clock arrives for TIMEOUT_CYCLES system clocks during a frame, the partial frame is abandoned. The next start bit begins a fresh frame.
- R11: The port returns {4'b0, vector} when the identifier equals 12 and returns 0 for every other identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ps2Clk | input | 1 | Keyboard clock line, asynchronous |
| ps2Data | input | 1 | Keyboard data line, asynchronous |
| portId | input | 4 | I/O read port identifier |
| portData | output | 8 | Read data, combinational from portId |

## Verification
A change of the vector is due on the third system clock edge after the falling keyboard clock of the stop bit: two synchroniser stages, then the vector register. Every expectation is therefore sampled on a falling system clock at least one keyboard half-bit (20 system clocks) after that stop-bit edge. The port read is combinational, so a new portId is checked one falling system clock after it is driven. The timeout case holds the keyboard clock high for more than twice TIMEOUT_CYCLES before the next frame. That guarantees the counter has expired whatever phase the partial frame left it in.

// File: rtl/ps2_arrow_pkg.sv
package ps2_arrow_pkg;

  localparam int NUM_KEYS = 4;
  localparam int KEY_IDX_W = $clog2(NUM_KEYS);

  localparam logic [7:0] CODE_EXT   = 8'hE0;
  localparam logic [7:0] CODE_BREAK = 8'hF0;

  typedef struct packed {
    logic                 shiftEn;
    logic                 frameActive;
    logic                 setKey;
    logic                 clrKey;
    logic [KEY_IDX_W-1:0] keyIdx;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    PARSE_IDLE,
    PARSE_EXT,
    PARSE_BREAK
  } parseState_t;

  // returns {hit, index}; index order defines the state vector layout
  function automatic logic [KEY_IDX_W:0] arrowLookup(input logic [7:0] code);
    case (code)
      8'h72:   arrowLookup = {1'b1, 2'd0};
      8'h75:   arrowLookup = {1'b1, 2'd1};
      8'h6B:   arrowLookup = {1'b1, 2'd2};
      8'h74:   arrowLookup = {1'b1, 2'd3};
      default: arrowLookup = '0;
    endcase
  endfunction

endpackage

// File: rtl/ps2_arrow_datapath.sv
module ps2_arrow_datapath
  import ps2_arrow_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ps2ClkIn,
  input  logic                ps2DataIn,
  input  ctrlStrobe_t         ctrl,
  output logic                fallEdge,
  output logic                dataBit,
  output logic [8:0]          frameBits,
  output logic                parityOk,
  output logic                timeoutHit,
  output logic [NUM_KEYS-1:0] keyState
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic                   clkPrev;
  logic [8:0]             shiftReg;
  logic [TW-1:0]          idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '1;
      dataSync <= '1;
      clkPrev  <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], ps2ClkIn};
      dataSync <= {dataSync[SYNC_STAGES-2:0], ps2DataIn};
      clkPrev  <= clkSync[SYNC_STAGES-1];
    end
  end

  assign fallEdge = clkPrev & ~clkSync[SYNC_STAGES-1];
  assign dataBit  = dataSync[SYNC_STAGES-1];

  // data bits then parity, shifted in from the top
  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (ctrl.shiftEn) shiftReg <= {dataBit, shiftReg[8:1]};
  end

  assign frameBits = shiftReg;
  assign parityOk  = ^shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN || !ctrl.frameActive || fallEdge) idleCnt <= '0;
    else if (!timeoutHit)                       idleCnt <= idleCnt + 1'b1;
  end

  assign timeoutHit = (idleCnt == TW'(TIMEOUT_CYCLES));

  always_ff @(posedge clk) begin
    if (!rstN)            keyState <= '0;
    else if (ctrl.setKey) keyState[ctrl.keyIdx] <= 1'b1;
    else if (ctrl.clrKey) keyState[ctrl.keyIdx] <= 1'b0;
  end

  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.setKey || ctrl.clrKey) |=> $stable(keyState));

  assert_press_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setKey |=> keyState[$past(ctrl.keyIdx)]);

  assert_release_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrKey |=> !keyState[$past(ctrl.keyIdx)]);

endmodule

// File: rtl/ps2_arrow_control.sv
module ps2_arrow_control
  import ps2_arrow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fallEdge,
  input  logic        dataBit,
  input  logic [8:0]  frameBits,
  input  logic        parityOk,
  input  logic        timeoutHit,
  output ctrlStrobe_t ctrl
);

  localparam int FRAME_BITS = 11;
  localparam int LAST_BIT   = FRAME_BITS - 1;
  localparam int CW         = $clog2(FRAME_BITS);

  logic [CW-1:0]  bitCnt;
  parseState_t    parse;
  logic           edgeOk;
  logic           frameDone;
  logic           frameGood;
  logic [KEY_IDX_W:0] lookup;

  assign edgeOk    = fallEdge && !timeoutHit;
  assign frameDone = edgeOk && (bitCnt == CW'(LAST_BIT));
  assign frameGood = frameDone && dataBit && parityOk;
  assign lookup    = arrowLookup(frameBits[7:0]);

  always_comb begin
    ctrl             = '0;
    ctrl.frameActive = (bitCnt != '0);
    ctrl.shiftEn     = edgeOk && (bitCnt != '0) && (bitCnt != CW'(LAST_BIT));
    ctrl.keyIdx      = lookup[KEY_IDX_W-1:0];
    ctrl.setKey      = frameGood && lookup[KEY_IDX_W] && (parse == PARSE_EXT);
    ctrl.clrKey      = frameGood && lookup[KEY_IDX_W] && (parse == PARSE_BREAK);
  end

  always_ff @(posedge clk) begin
    if (!rstN || timeoutHit) begin
      bitCnt <= '0;
    end else if (fallEdge) begin
      if (bitCnt == '0)                bitCnt <= dataBit ? '0 : CW'(1);
      else if (bitCnt == CW'(LAST_BIT)) bitCnt <= '0;
      else                             bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parse <= PARSE_IDLE;
    end else if (frameDone) begin
      if (!frameGood) parse <= PARSE_IDLE;
      else begin
        case (parse)
          PARSE_IDLE: parse <= (frameBits[7:0] == CODE_EXT)   ? PARSE_EXT   : PARSE_IDLE;
          PARSE_EXT:  parse <= (frameBits[7:0] == CODE_BREAK) ? PARSE_BREAK : PARSE_IDLE;
          default:    parse <= PARSE_IDLE;
        endcase
      end
    end
  end

  assert_timeout_abandons_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> (bitCnt == '0));

  assert_single_update_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.setKey, ctrl.clrKey}));

  assert_bad_parity_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !parityOk) |=> (parse == PARSE_IDLE));

  assert_bad_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !dataBit) |=> (parse == PARSE_IDLE));

endmodule

// File: rtl/ps2_arrow_tracker.sv
module ps2_arrow_tracker
  import ps2_arrow_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25000,
  parameter int PORT_ID_W      = 4,
  parameter int PORT_OFFSET    = 12,
  parameter int PORT_DATA_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ps2Clk,
  input  logic                   ps2Data,
  input  logic [PORT_ID_W-1:0]   portId,
  output logic [PORT_DATA_W-1:0] portData
);

  ctrlStrobe_t         ctrl;
  logic                fallEdge;
  logic                dataBit;
  logic [8:0]          frameBits;
  logic                parityOk;
  logic                timeoutHit;
  logic [NUM_KEYS-1:0] keyState;

  ps2_arrow_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES   (2)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ps2ClkIn  (ps2Clk),
    .ps2DataIn (ps2Data),
    .ctrl      (ctrl),
    .fallEdge  (fallEdge),
    .dataBit   (dataBit),
    .frameBits (frameBits),
    .parityOk  (parityOk),
    .timeoutHit(timeoutHit),
    .keyState  (keyState)
  );

  ps2_arrow_control control_i (
    .clk       (clk),
    .rstN      (rstN),
    .fallEdge  (fallEdge),
    .dataBit   (dataBit),
    .frameBits (frameBits),
    .parityOk  (parityOk),
    .timeoutHit(timeoutHit),
    .ctrl      (ctrl)
  );

  assign portData = (portId == PORT_ID_W'(PORT_OFFSET))
                  ? PORT_DATA_W'(keyState) : '0;

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    portData[PORT_DATA_W-1:NUM_KEYS] == '0);

endmodule

// File: tb/ps2_arrow_tracker_tb.sv
module ps2_arrow_tracker_tb_top;

  localparam int TO_CYC  = 300;
  localparam int HALF    = 20;
  localparam int NV      = 29;
  localparam logic [3:0] KEY_PORT = 4'd12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ps2Clk = 1'b1;
  logic       ps2Data = 1'b1;
  logic [3:0] portId = KEY_PORT;
  logic [7:0] portData;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  ps2_arrow_tracker #(.TIMEOUT_CYCLES(TO_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .ps2Clk(ps2Clk), .ps2Data(ps2Data),
    .portId(portId), .portData(portData)
  );

  // {req, badParity, code, expected vector}
  localparam logic [16:0] VEC [NV] = '{
    {4'd3, 1'b0, 8'hE0, 4'h0}, {4'd3, 1'b0, 8'h72, 4'h1},   // R3 up press
    {4'd5, 1'b0, 8'hE0, 4'h1}, {4'd5, 1'b0, 8'h6B, 4'h5},   // R5 left
    {4'd4, 1'b0, 8'hE0, 4'h5}, {4'd4, 1'b0, 8'hF0, 4'h5},
    {4'd4, 1'b0, 8'h72, 4'h4},                               // R4 up release
    {4'd6, 1'b0, 8'h72, 4'h4}, {4'd6, 1'b0, 8'hF0, 4'h4},
    {4'd6, 1'b0, 8'h6B, 4'h4},                               // R6 no prefix
    {4'd5, 1'b0, 8'hE0, 4'h4}, {4'd5, 1'b0, 8'h74, 4'hC},   // R5 right
    {4'd5, 1'b0, 8'hE0, 4'hC}, {4'd5, 1'b0, 8'h75, 4'hE},   // R5 down
    {4'd7, 1'b0, 8'hE0, 4'hE}, {4'd7, 1'b0, 8'h12, 4'hE},
    {4'd7, 1'b0, 8'hF0, 4'hE}, {4'd7, 1'b0, 8'h74, 4'hE},   // R7 parser reset
    {4'd4, 1'b0, 8'hE0, 4'hE}, {4'd4, 1'b0, 8'hF0, 4'hE},
    {4'd4, 1'b0, 8'h74, 4'h6},                               // R4 right release
    {4'd8, 1'b0, 8'hE0, 4'h6}, {4'd8, 1'b1, 8'hF0, 4'h6},
    {4'd8, 1'b0, 8'h75, 4'h6},                               // R8 bad parity mid
    {4'd8, 1'b0, 8'hE0, 4'h6}, {4'd8, 1'b1, 8'h72, 4'h6},   // R8 bad parity code
    {4'd2, 1'b0, 8'hE0, 4'h6}, {4'd2, 1'b0, 8'hF0, 4'h6},
    {4'd2, 1'b0, 8'h75, 4'h4}                                // R2 framing
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: portData=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [10:0] bits, input int count);
    for (int i = 0; i < count; i++) begin
      ps2Data = bits[i];
      waitCyc(HALF);
      ps2Clk = 1'b0;
      waitCyc(HALF);
      ps2Clk = 1'b1;
    end
    ps2Data = 1'b1;
    waitCyc(3 * HALF);
  endtask

  task automatic sendFrame(input logic [7:0] code, input bit badPar, input bit badStop);
    logic par;
    par = ~(^code) ^ badPar;
    sendBits({~badStop, par, code, 1'b0}, 11);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    waitCyc(5);
    // R1 reset state at the key port and elsewhere
    check("R1", portData, 8'h00);
    rstN = 1'b1;
    waitCyc(5);
    check("R1", portData, 8'h00);
    portId = 4'd3;
    waitCyc(1);
    check("R1", portData, 8'h00);
    portId = KEY_PORT;

    for (int v = 0; v < NV; v++) begin
      sendFrame(VEC[v][11:4], VEC[v][12], 1'b0);
      check($sformatf("R%0d vec%0d", VEC[v][16:13], v), portData, {4'h0, VEC[v][3:0]});
    end

    // R9 stop bit 0 on the cursor code after the prefix
    sendFrame(8'hE0, 1'b0, 1'b0);
    sendFrame(8'h72, 1'b0, 1'b1);
    check("R9", portData, 8'h04);
    sendFrame(8'h75, 1'b0, 1'b0);
    check("R9", portData, 8'h04);

    // R10 partial frame abandoned after idle clock
    sendBits(11'b000_0000_0000, 4);
    waitCyc(2 * TO_CYC + 50);
    sendFrame(8'hE0, 1'b0, 1'b0);
    sendFrame(8'h72, 1'b0, 1'b0);
    check("R10", portData, 8'h05);

    // R11 port decode
    portId = 4'd8;
    waitCyc(1);
    check("R11", portData, 8'h00);
    portId = 4'd13;
    waitCyc(1);
    check("R11", portData, 8'h00);
    portId = KEY_PORT;
    waitCyc(1);
    check("R11", portData, 8'h05);

    // R1 reset in operation clears the vector
    rstN = 1'b0;
    waitCyc(3);
    check("R1", portData, 8'h00);
    rstN = 1'b1;
    waitCyc(3);
    check("R1", portData, 8'h00);

    finishRun();
  end

endmodule